// File: doc/BRIEF.md
# Four-State Logic Gate Evaluator

This block evaluates basic gates (AND, OR, XOR, NOT) on signals that carry four values, so that a logic emulation engine can model unknown and floating nets instead of only clean zeros and ones. Each signal value travels as a two-bit code. A mode input sets how unknown operands are treated. Pessimistic mode lets any unknown that is not masked spread to the result. Optimistic mode replaces every unknown with a configurable default bit. Symbolic mode returns a known value only when every possible resolution of the unknowns produces that same value.

A number of independent lanes share one opcode, mode and default bit, and each lane has its own pair of operands. A per-lane tie flag marks two operands that come from the same net. Symbolic mode then counts only resolutions in which both operands take the same value, so an unknown XORed with itself is known to be 0. Results are registered and update only in a cycle where the enable is high.

Top module: `fsv_gate_eval`

## Requirements
- R1: While rst_n is low, every lane of res reads 2'b00 (logic 0). The reset acts at once and does not wait for a clock edge.
- R2: Values are coded 00 = 0, 01 = 1, 10 = X and 11 = Z. A Z operand is evaluated exactly as an X, and res never shows 11.
- R3: With xmode 00 (pessimistic), an unknown operand makes the result X unless a controlling value masks it. This means XOR with any X gives X, NOT of X gives X, and the tie flag has no effect.
- R4: With xmode 01 (optimistic), every X or Z operand is replaced by opt_one before a plain two-valued gate is applied, so the result is never X. NOT of X therefore gives the inverse of opt_one.
- R5: With xmode 10 (symbolic), the result is a known value exactly when all resolutions of the unknown operands give that value, and X otherwise. When tie is set and both operands are unknown, only resolutions with equal values are counted.
- R6: In every mode, a 0 operand to AND gives 0 and a 1 operand to OR gives 1, whatever the other operand is.
- R7: xmode 11 behaves exactly as pessimistic mode.
- R8: On a rising clock edge with eval_en high, res takes the results for the current inputs. With eval_en low, res holds its value.
- R9: Each lane takes only its own operand slices and tie bit (lane i uses bits [2i+1:2i] and tie[i]).
- R10: opcode codes are 00 = AND, 01 = OR, 10 = XOR, 11 = NOT. NOT takes operand A and ignores operand B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| eval_en | input | 1 | Clock enable for the result register |
| opcode | input | 2 | Gate select, shared by all lanes |
| xmode | input | 2 | Unknown-handling mode, shared by all lanes |
| opt_one | input | 1 | Default value given to unknowns in optimistic mode |
| tie | input | LANES | Per-lane flag: the two operands come from the same net |
| opnd_a | input | 2*LANES | Operand A, two bits per lane |
| opnd_b | input | 2*LANES | Operand B, two bits per lane |
| res | output | 2*LANES | Registered result, two bits per lane |

## Verification
The hardest case to reach is the symbolic result on tied operands: it needs both operands unknown, written as X, Z or a mix of the two, at the same time as the tie bit and the symbolic mode. The bench reaches it with an exhaustive sweep. The sweep covers every operand pair, including Z, and every opcode, mode, default bit and tie value. Lane 1 gets the swapped operands and the inverted tie bit, so each cycle checks two different combinations at once.

// File: rtl/fsv_pkg.sv
package fsv_pkg;
  typedef enum logic [1:0] {V0 = 2'b00, V1 = 2'b01, VX = 2'b10, VZ = 2'b11} fsv_val_e;
  typedef enum logic [1:0] {OP_AND = 2'b00, OP_OR = 2'b01, OP_XOR = 2'b10, OP_NOT = 2'b11} fsv_op_e;
  typedef enum logic [1:0] {XM_PESS = 2'b00, XM_OPT = 2'b01, XM_SYM = 2'b10, XM_RSVD = 2'b11} fsv_xmode_e;

  localparam int VAL_W = 2;

  // plain two-valued gate
  function automatic logic bool_gate(fsv_op_e op, logic a, logic b);
    case (op)
      OP_AND:  return a & b;
      OP_OR:   return a | b;
      OP_XOR:  return a ^ b;
      default: return ~a;
    endcase
  endfunction
endpackage

// File: rtl/fsv_zfold.sv
module fsv_zfold
  import fsv_pkg::*;
(
  input  logic [1:0] val_in,
  output fsv_val_e   val_out,
  output logic       is_unk
);
  always_comb begin
    is_unk  = val_in[1];
    val_out = val_in[1] ? VX : fsv_val_e'(val_in);
  end
endmodule

// File: rtl/fsv_lane_eval.sv
module fsv_lane_eval
  import fsv_pkg::*;
(
  input  logic [1:0] a_in,
  input  logic [1:0] b_in,
  input  logic [1:0] opcode,
  input  logic [1:0] xmode,
  input  logic       opt_one,
  input  logic       tie,
  output logic [1:0] y
);
  fsv_val_e   a_n, b_n;
  logic       a_x, b_x;
  fsv_op_e    op;
  fsv_xmode_e md;
  fsv_val_e   y_pess, y_opt, y_sym, y_sel;
  logic       ra, rb, seen0, seen1;

  fsv_zfold u_fold_a (.val_in(a_in), .val_out(a_n), .is_unk(a_x));
  fsv_zfold u_fold_b (.val_in(b_in), .val_out(b_n), .is_unk(b_x));

  always_comb begin
    op = fsv_op_e'(opcode);
    md = (fsv_xmode_e'(xmode) == XM_RSVD) ? XM_PESS : fsv_xmode_e'(xmode);
  end

  // pessimistic: any unmasked unknown spreads
  always_comb begin
    case (op)
      OP_AND: begin
        if (a_n == V0 || b_n == V0)      y_pess = V0;
        else if (a_x || b_x)             y_pess = VX;
        else                             y_pess = V1;
      end
      OP_OR: begin
        if (a_n == V1 || b_n == V1)      y_pess = V1;
        else if (a_x || b_x)             y_pess = VX;
        else                             y_pess = V0;
      end
      OP_XOR: begin
        if (a_x || b_x)                  y_pess = VX;
        else                             y_pess = (a_n[0] ^ b_n[0]) ? V1 : V0;
      end
      default: begin
        if (a_x)                         y_pess = VX;
        else                             y_pess = a_n[0] ? V0 : V1;
      end
    endcase
  end

  // optimistic: unknowns take the default bit
  always_comb begin
    ra    = a_x ? opt_one : a_n[0];
    rb    = b_x ? opt_one : b_n[0];
    y_opt = bool_gate(op, ra, rb) ? V1 : V0;
  end

  // symbolic: enumerate every resolution of the unknowns
  always_comb begin
    seen0 = 1'b0;
    seen1 = 1'b0;
    for (int ia = 0; ia < 2; ia++) begin
      for (int ib = 0; ib < 2; ib++) begin
        if ((a_x || (ia[0] == a_n[0])) &&
            (b_x || (ib[0] == b_n[0])) &&
            !(tie && a_x && b_x && (ia[0] != ib[0]))) begin
          if (bool_gate(op, ia[0], ib[0])) seen1 = 1'b1;
          else                             seen0 = 1'b1;
        end
      end
    end
    if (seen0 && seen1) y_sym = VX;
    else if (seen1)     y_sym = V1;
    else                y_sym = V0;
  end

  always_comb begin
    case (md)
      XM_OPT:  y_sel = y_opt;
      XM_SYM:  y_sel = y_sym;
      default: y_sel = y_pess;
    endcase
    y = y_sel;
  end

  // checks on the combined lane result
  always_comb begin
    if (op == OP_AND && (a_in == 2'b00 || b_in == 2'b00))
      assert_and_ctrl_R6: assert (y == 2'b00);
    if (op == OP_OR && (a_in == 2'b01 || b_in == 2'b01))
      assert_or_ctrl_R6: assert (y == 2'b01);
    if (md == XM_OPT)
      assert_opt_known_R4: assert (y[1] == 1'b0);
    if (!a_in[1] && !b_in[1])
      assert_known_in_known_out_R5: assert (y[1] == 1'b0);
  end
endmodule

// File: rtl/fsv_gate_eval.sv
module fsv_gate_eval
  import fsv_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   eval_en,
  input  logic [1:0]             opcode,
  input  logic [1:0]             xmode,
  input  logic                   opt_one,
  input  logic [LANES-1:0]       tie,
  input  logic [VAL_W*LANES-1:0] opnd_a,
  input  logic [VAL_W*LANES-1:0] opnd_b,
  output logic [VAL_W*LANES-1:0] res
);
  localparam int BUS_W = VAL_W * LANES;

  logic [BUS_W-1:0] lane_y;
  logic [BUS_W-1:0] res_d;
  logic [BUS_W-1:0] res_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fsv_lane_eval u_lane (
      .a_in   (opnd_a[VAL_W*g +: VAL_W]),
      .b_in   (opnd_b[VAL_W*g +: VAL_W]),
      .opcode (opcode),
      .xmode  (xmode),
      .opt_one(opt_one),
      .tie    (tie[g]),
      .y      (lane_y[VAL_W*g +: VAL_W])
    );

    assert_no_z_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
      res_q[VAL_W*g +: VAL_W] != 2'b11);
  end

  // next state
  always_comb begin
    res_d = eval_en ? lane_y : res_q;
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else        res_q <= res_d;
  end

  assign res = res_q;

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(eval_en) |-> $stable(res_q));
  assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eval_en |=> (res_q == $past(lane_y)));
endmodule

// File: tb/sim_fsv_gate_eval.sv
`timescale 1ns/1ps
module sim_fsv_gate_eval;
  localparam int LANES = 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             eval_en;
  logic [1:0]       opcode, xmode;
  logic             opt_one;
  logic [LANES-1:0] tie;
  logic [2*LANES-1:0] opnd_a, opnd_b;
  logic [2*LANES-1:0] res;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  fsv_gate_eval #(.LANES(LANES)) u0 (
    .clk(clk), .rst_n(rst_n), .eval_en(eval_en), .opcode(opcode), .xmode(xmode),
    .opt_one(opt_one), .tie(tie), .opnd_a(opnd_a), .opnd_b(opnd_b), .res(res)
  );

  // reference from the requirements
  function automatic logic [1:0] ref_val(logic [1:0] a, logic [1:0] b, logic [1:0] op,
                                         logic [1:0] md, logic dflt, logic t);
    bit ua = a[1], ub = b[1];
    bit ka = a[0], kb = b[0];
    bit s0 = 0, s1 = 0, r;
    int m = (md == 2'd3) ? 0 : int'(md);
    if (m == 1) begin
      bit xa = ua ? dflt : ka;
      bit xb = ub ? dflt : kb;
      case (op)
        2'd0: r = xa & xb;
        2'd1: r = xa | xb;
        2'd2: r = xa ^ xb;
        default: r = !xa;
      endcase
      return {1'b0, r};
    end
    if (m == 0) begin
      case (op)
        2'd0: return ((!ua && !ka) || (!ub && !kb)) ? 2'b00 : (ua || ub) ? 2'b10 : 2'b01;
        2'd1: return ((!ua && ka) || (!ub && kb)) ? 2'b01 : (ua || ub) ? 2'b10 : 2'b00;
        2'd2: return (ua || ub) ? 2'b10 : {1'b0, ka ^ kb};
        default: return ua ? 2'b10 : {1'b0, !ka};
      endcase
    end
    for (int va = 0; va < 2; va++)
      for (int vb = 0; vb < 2; vb++) begin
        if (!ua && va != int'(ka)) continue;
        if (!ub && vb != int'(kb)) continue;
        if (t && ua && ub && va != vb) continue;
        case (op)
          2'd0: r = va[0] & vb[0];
          2'd1: r = va[0] | vb[0];
          2'd2: r = va[0] ^ vb[0];
          default: r = !va[0];
        endcase
        if (r) s1 = 1; else s0 = 1;
      end
    return (s0 && s1) ? 2'b10 : (s1 ? 2'b01 : 2'b00);
  endfunction

  function automatic string tag_of(logic [1:0] a, logic [1:0] b, logic [1:0] op,
                                   logic [1:0] md, int lane);
    if (lane == 1) return "R9";
    if (md == 2'd3) return "R7";
    if (op == 2'd0 && (a == 2'b00 || b == 2'b00)) return "R6";
    if (op == 2'd1 && (a == 2'b01 || b == 2'b01)) return "R6";
    if (a == 2'b11 || b == 2'b11) return "R2";
    if (op == 2'd3) return "R10";
    case (md)
      2'd0: return "R3";
      2'd1: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; eval_en = 1'b0; opcode = 2'd0; xmode = 2'd0; opt_one = 1'b0;
    tie = '0; opnd_a = '0; opnd_b = '0;
    repeat (3) @(negedge clk);
    for (int l = 0; l < LANES; l++) check("R1", res[2*l +: 2], 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_sweep();
    for (int d = 0; d < 2; d++)
      for (int md = 0; md < 4; md++)
        for (int op = 0; op < 4; op++)
          for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
              for (int t = 0; t < 2; t++) begin
                opt_one = d[0]; xmode = md[1:0]; opcode = op[1:0];
                opnd_a = {b[1:0], a[1:0]};
                opnd_b = {a[1:0], b[1:0]};
                tie = {~t[0], t[0]};
                eval_en = 1'b1;
                @(negedge clk);
                check(tag_of(a[1:0], b[1:0], op[1:0], md[1:0], 0), res[1:0],
                      ref_val(a[1:0], b[1:0], op[1:0], md[1:0], d[0], t[0]));
                check(tag_of(b[1:0], a[1:0], op[1:0], md[1:0], 1), res[3:2],
                      ref_val(b[1:0], a[1:0], op[1:0], md[1:0], d[0], ~t[0]));
              end
  endtask

  task automatic t_hold();
    // load XOR of 1,0 -> 1 on lane 0, then freeze and change inputs
    opcode = 2'd2; xmode = 2'd0; opt_one = 1'b0; tie = '0;
    opnd_a = 4'b0101; opnd_b = 4'b0000; eval_en = 1'b1;
    @(negedge clk);
    check("R8", res[1:0], 2'b01);
    eval_en = 1'b0; opnd_a = 4'b0000; opcode = 2'd0;
    repeat (3) @(negedge clk);
    check("R8", res[1:0], 2'b01);
    check("R8", res[3:2], 2'b01);
    eval_en = 1'b1;
    @(negedge clk);
    check("R8", res[1:0], 2'b00);
  endtask

  task automatic t_async_reset();
    opcode = 2'd1; xmode = 2'd0; opnd_a = 4'b0101; opnd_b = 4'b0000; eval_en = 1'b1;
    @(negedge clk);
    check("R8", res, 4'b0101);
    #1 rst_n = 1'b0;
    #0.5;
    check("R1", res, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    eval_en = 1'b0;
    @(negedge clk);
    check("R1", res, 4'b0000);
  endtask

  initial begin
    t_reset();
    t_sweep();
    t_hold();
    t_async_reset();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule